// File: doc/BRIEF.md
# Programmable Baud Clock Divider

This block turns a fast reference clock into the sixteen-times-oversampling clock that a serial port's receiver and transmitter run on. Software loads a 16-bit divisor as two bytes, low and high, through a simple byte-write port. From the divisor the block derives a periodic output on `baud_o`. For a divisor N of 3 or more, `baud_o` goes high for one reference cycle in every N. Its frequency is therefore the reference divided by N, which is sixteen times the resulting baud rate.

Three small divisors are not counted in the normal way. A divisor of 0 gives a divide-by-3 output that is high one cycle in three. A divisor of 2 gives a square wave at half the reference. A divisor of 1 gives the reference clock itself, inverted. Every byte write restarts the count from the new divisor straight away, so a freshly programmed rate is not held up by what is left of a long old count.

Top module: `baud_div_top`

## Requirements
- R1: After reset both divisor bytes are 0 and the output runs the divisor-0 pattern: low at the first clock edge after reset is released, high only at the 3rd, 6th, 9th, ... edge.
- R2: A write with `wr_en`=1 and `wr_sel`=0 loads `wr_data` into the low byte (divisor bits 7:0). A write with `wr_sel`=1 loads the high byte (bits 15:8). The other byte keeps its value.
- R3: A write restarts the count at the edge that takes it. `baud_o` is low after that edge, and the first high cycle follows the P-th edge after it, where P is the period of the new divisor.
- R4: For a divisor N ≥ 3, `baud_o` is high for exactly one cycle out of every N reference cycles.
- R5: A divisor of 0 gives period 3, with one high cycle and two low cycles.
- R6: A divisor of 2 gives period 2, alternating one high cycle and one low cycle.
- R7: A divisor of 1 makes `baud_o` equal to the inverse of `clk`, starting at the edge that stores it.
- R8: With `wr_en`=0, `wr_sel` and `wr_data` have no effect. The divisor and the running pattern continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte written to the selected divisor half |
| baud_o | output | 1 | Divided clock output |

## Verification
A write takes effect at the rising edge that samples it. After that edge the output is low. For a period P, the first high cycle is registered on the P-th following edge, and the bench counts edges from the write to predict this. Every counted output is sampled one nanosecond after the falling edge, in the middle of the cycle that follows each registering edge. The divide-by-one case has no register in its path, so it is sampled in both clock phases: high while `clk` is low and low while `clk` is high. Divisor bytes take effect on the next edge, and the bench's model of the divisor is updated on that same edge.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    // How a divisor value is turned into an output waveform.
    typedef enum logic [1:0] {
        MODE_DIV3   = 2'd0,   // divisor 0: fixed divide-by-3
        MODE_INVCLK = 2'd1,   // divisor 1: inverted reference
        MODE_DIV2   = 2'd2,   // divisor 2: half-rate square wave
        MODE_COUNT  = 2'd3    // divisor >= 3: one pulse per N cycles
    } div_mode_e;

    function automatic div_mode_e classify(input logic [15:0] div);
        if (div == 16'd0)      return MODE_DIV3;
        else if (div == 16'd1) return MODE_INVCLK;
        else if (div == 16'd2) return MODE_DIV2;
        else                   return MODE_COUNT;
    endfunction

endpackage

// File: rtl/bdiv_latches.sv
module bdiv_latches #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = DIV_W / BYTE_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q_o,
    output logic [DIV_W-1:0]  div_d_o,
    output logic              load_o
);

    typedef struct packed {
        logic [NB-1:0][BYTE_W-1:0] bytes;
    } lat_s;

    lat_s st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NB; i++) begin
            if (wr_en && (wr_sel == SEL_W'(i))) begin
                st_d.bytes[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_q_o = st_q.bytes;
    assign div_d_o = st_d.bytes;
    assign load_o  = wr_en;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(div_q_o));

    p_low_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (div_q_o[BYTE_W-1:0] == $past(wr_data)));

endmodule

// File: rtl/bdiv_reload.sv
module bdiv_reload
    import baud_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] reload_o,
    output logic             invclk_o
);

    div_mode_e mode;

    always_comb begin
        mode = classify(16'(div_i));
        unique case (mode)
            MODE_DIV3:   reload_o = DIV_W'(2);
            MODE_INVCLK: reload_o = '0;
            MODE_DIV2:   reload_o = DIV_W'(1);
            default:     reload_o = div_i - DIV_W'(1);
        endcase
        invclk_o = (mode == MODE_INVCLK);
    end

endmodule

// File: rtl/bdiv_counter.sv
module bdiv_counter #(
    parameter int DIV_W      = 16,
    parameter int RST_RELOAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] reload_i,
    input  logic             invclk_i,
    output logic             pulse_o,
    output logic             invclk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pulse;
        logic             invclk;
    } cnt_s;

    cnt_s st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (load_i) begin
            st_d.cnt    = reload_i;
            st_d.invclk = invclk_i;
        end else if (st_q.cnt == '0) begin
            st_d.cnt   = reload_i;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= DIV_W'(RST_RELOAD);
            st_q.pulse  <= 1'b0;
            st_q.invclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o  = st_q.pulse;
    assign invclk_o = st_q.invclk;

    p_cnt_within_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |-> (st_q.cnt <= reload_i));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && reload_i != '0) |=> !st_q.pulse);

endmodule

// File: rtl/baud_div_top.sv
module baud_div_top #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = DIV_W / BYTE_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              baud_o
);

    logic [DIV_W-1:0] div_q, div_d, reload;
    logic             load, invclk_d, invclk_q, pulse;

    bdiv_latches #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_latches (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .div_q_o (div_q),
        .div_d_o (div_d),
        .load_o  (load)
    );

    // Uses the incoming divisor so a write reloads with its new value;
    // with no write the incoming value equals the stored one.
    bdiv_reload #(.DIV_W(DIV_W)) u_reload (
        .div_i    (div_d),
        .reload_o (reload),
        .invclk_o (invclk_d)
    );

    bdiv_counter #(.DIV_W(DIV_W), .RST_RELOAD(2)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .reload_i (reload),
        .invclk_i (invclk_d),
        .pulse_o  (pulse),
        .invclk_o (invclk_q)
    );

    assign baud_o = invclk_q ? ~clk : pulse;

    p_write_quiets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !pulse);

    p_invclk_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        invclk_q |-> (div_q == DIV_W'(1)));

endmodule

// File: tb/tb_baud_div_top.sv
`timescale 1ns/1ps
module tb_baud_div_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // bench model of the divisor and edges since the last restart
    logic [7:0] m_lo = 8'h00, m_hi = 8'h00;
    int         k = 0;
    bit         written = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    baud_div_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .baud_o  (baud_o)
    );

    function automatic int period_of(input int d);
        if (d == 0) return 3;
        if (d == 2) return 2;
        return d;
    endfunction

    function automatic bit expect_out(input int d, input int edges);
        int p;
        p = period_of(d);
        return (edges > 0) && (edges % p == 0);
    endfunction

    function automatic string tag_of(input int d, input int edges, input bit wr);
        if (d == 1) return "R7";
        if (!wr)    return "R1";
        if (edges <= period_of(d)) return "R3";
        if (d == 0) return "R5";
        if (d == 2) return "R6";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: baud_o=%0b expected %0b (div=%0d edges=%0d t=%0t)",
                     tag, act, exp, {m_hi, m_lo}, k, $time);
        end
    endtask

    // one reference cycle: drive, take the edge, sample both phases
    task automatic cycle(input bit en, input bit sel, input logic [7:0] data);
        int d;
        wr_en = en; wr_sel = sel; wr_data = data;
        @(posedge clk);
        if (en) begin
            if (sel) m_hi = data; else m_lo = data;
            k = 0;
            written = 1'b1;
        end else begin
            k++;
        end
        d = {m_hi, m_lo};
        #1;
        if (d == 1) check("R7", baud_o, 1'b0);
        @(negedge clk);
        #1;
        if (d == 1) check("R7", baud_o, 1'b1);
        else        check(tag_of(d, k, written), baud_o, expect_out(d, k));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'($urandom), 8'($urandom));  // R8
    endtask

    task automatic set_div(input logic [15:0] d);
        cycle(1'b1, 1'b1, d[15:8]);
        cycle(1'b1, 1'b0, d[7:0]);
    endtask

    initial begin
        void'($urandom(32'h5eed_0b0d));
        repeat (3) @(negedge clk);
        #1;
        check("R1", baud_o, 1'b0);
        rst_n = 1'b1;
        k = 0;
        // R1: reset divisor gives the divide-by-3 pattern
        idle(12);
        // R2 / R4: divisor 5 loaded through both bytes
        set_div(16'd5);
        idle(17);
        // R5: divisor 0 explicitly
        set_div(16'd0);
        idle(10);
        // R6: divisor 2
        set_div(16'd2);
        idle(9);
        // R7: divisor 1, then leave it again
        set_div(16'd1);
        idle(6);
        set_div(16'd3);
        idle(10);
        // R2: high byte alone, divisor 0x0103
        cycle(1'b1, 1'b1, 8'h01);
        idle(270);
        // R3: restart in the middle of a long count
        set_div(16'd40);
        idle(17);
        cycle(1'b1, 1'b0, 8'd7);
        idle(20);
        // random mix of byte writes and idle stretches
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(7) == 0) begin
                if ($urandom_range(9) == 0)
                    cycle(1'b1, 1'b1, 8'($urandom_range(1)));
                else
                    cycle(1'b1, 1'b0, 8'($urandom_range(12)));
            end else begin
                cycle(1'b0, 1'($urandom), 8'($urandom));
            end
            if (n % 97 == 0 && m_hi != 0) set_div(16'($urandom_range(9)));
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete (expected finish)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule